// File: doc/BRIEF.md
# Fused Altitude Threshold Compare ALU Stage

This block is the execute-stage arithmetic unit of a small pipelined processor core. It carries the usual register-register operations, and one extra application-specific operation. It takes the opcode and function fields of an instruction with two 32-bit register operands. It decodes an internal operation select from those fields and produces the 32-bit result one clock later, together with a valid flag and the registered operation select.

The extra operation is a fused low-altitude test. A single register-format instruction with function code 0x10 answers "are both operands below the altitude floor?" as a 0/1 value. Code that once needed two set-less-than compares and two conditional branches now needs one ALU operation. Both compares run in parallel in fixed logic, so the test takes as long as any other ALU operation and has no data-dependent iteration.

Top module: `alt_thresh_alu`

## Requirements
- R1: An issued instruction with opcode 0 and function code 0x10 decodes to operation select 9, and `thr_hit_o` is 1 in the cycle its result is presented.
- R2: For operation 9, result bit 0 is 1 exactly when both operands, taken as signed 32-bit values, are less than 1000. This covers the boundaries 999 (below), 1000 and 1001 (not below) and all negative values (below).
- R3: For operation 9, result bits 31:1 are always 0.
- R4: With opcode 0, the existing function codes keep their operations: 0x20/0x21 add (select 1), 0x22/0x23 subtract (2), 0x24 and (3), 0x25 or (4), 0x26 xor (5), 0x27 nor (6), 0x2A signed set-less-than (7), 0x2B unsigned set-less-than (8).
- R5: A nonzero opcode, or opcode 0 with any other function code, decodes to operation select 0 with result 0 and `thr_hit_o` 0. This holds even when the function code is 0x10.
- R6: Outputs are registered. The result, select and flags for an input held in a cycle with `in_valid_i` high appear after the next rising clock edge. A cycle with `in_valid_i` low yields `res_valid_o` 0, select 0 and result 0.
- R7: While synchronous reset `rst` is high, the next edge clears `res_valid_o`, `thr_hit_o`, `op_sel_o` and `result_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction issued this cycle |
| opcode_i | input | 6 | Instruction major opcode field |
| funct_i | input | 6 | Register-format function field |
| opa_i | input | 32 | First source operand |
| opb_i | input | 32 | Second source operand |
| res_valid_o | output | 1 | Registered result is valid |
| thr_hit_o | output | 1 | Registered result belongs to the fused threshold operation |
| op_sel_o | output | 4 | Registered internal operation select |
| result_o | output | 32 | Registered operation result |

## Verification
The fused threshold test and the ordinary signed set-less-than share one issue slot and one result register. Both can therefore be in flight in adjacent cycles, with one result being presented while the other is being decoded. The bench issues an add and then the threshold operation back to back with no idle cycle between them, followed by the reverse order. It judges that each cycle's result, select and `thr_hit_o` belong to the instruction issued one cycle earlier and not to its neighbour. Boundary operands around 1000 and mixed-sign operands are also fed through both the threshold operation and set-less-than, to show the two comparisons stay separate.

// File: rtl/alt_thresh_pkg.sv
package alt_thresh_pkg;
  typedef enum logic [3:0] {
    ALU_NONE = 4'd0,
    ALU_ADD  = 4'd1,
    ALU_SUB  = 4'd2,
    ALU_AND  = 4'd3,
    ALU_OR   = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_NOR  = 4'd6,
    ALU_SLT  = 4'd7,
    ALU_SLTU = 4'd8,
    ALU_THR  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alt_op_decoder.sv
module alt_op_decoder
  import alt_thresh_pkg::*;
#(
  parameter int OPC_W     = 6,
  parameter int FN_W      = 6,
  parameter int THR_FUNCT = 'h10
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output alu_op_e          op_o
);
  localparam logic [FN_W-1:0] FN_THR = FN_W'(THR_FUNCT);

  always_comb begin
    op_o = ALU_NONE;
    if (valid_i && opcode_i == '0) begin
      unique case (funct_i)
        FN_THR:                 op_o = ALU_THR;
        FN_W'('h20), FN_W'('h21): op_o = ALU_ADD;
        FN_W'('h22), FN_W'('h23): op_o = ALU_SUB;
        FN_W'('h24):            op_o = ALU_AND;
        FN_W'('h25):            op_o = ALU_OR;
        FN_W'('h26):            op_o = ALU_XOR;
        FN_W'('h27):            op_o = ALU_NOR;
        FN_W'('h2A):            op_o = ALU_SLT;
        FN_W'('h2B):            op_o = ALU_SLTU;
        default:                op_o = ALU_NONE;
      endcase
    end
  end
endmodule

// File: rtl/alt_floor_cmp.sv
module alt_floor_cmp #(
  parameter int DATA_W = 32,
  parameter int FLOOR  = 1000
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              both_low_o
);
  localparam logic signed [DATA_W-1:0] FLOOR_S = DATA_W'(FLOOR);

  logic a_low, b_low;
  // Two independent signed compares evaluated in parallel.
  assign a_low      = $signed(a_i) < FLOOR_S;
  assign b_low      = $signed(b_i) < FLOOR_S;
  assign both_low_o = a_low & b_low;
endmodule

// File: rtl/alt_alu_core.sv
module alt_alu_core
  import alt_thresh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLOOR  = 1000
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  logic both_low;

  alt_floor_cmp #(.DATA_W(DATA_W), .FLOOR(FLOOR)) u_floor (
    .a_i       (a_i),
    .b_i       (b_i),
    .both_low_o(both_low)
  );

  always_comb begin
    unique case (op_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_NOR:  y_o = ~(a_i | b_i);
      ALU_SLT:  y_o = {{(DATA_W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU: y_o = {{(DATA_W-1){1'b0}}, a_i < b_i};
      ALU_THR:  y_o = {{(DATA_W-1){1'b0}}, both_low};
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/alt_thresh_alu.sv
module alt_thresh_alu
  import alt_thresh_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OPC_W     = 6,
  parameter int FN_W      = 6,
  parameter int FLOOR     = 1000,
  parameter int THR_FUNCT = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [FN_W-1:0]   funct_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              res_valid_o,
  output logic              thr_hit_o,
  output logic [3:0]        op_sel_o,
  output logic [DATA_W-1:0] result_o
);
  alu_op_e           op_d;
  logic [DATA_W-1:0] y_d;

  alt_op_decoder #(.OPC_W(OPC_W), .FN_W(FN_W), .THR_FUNCT(THR_FUNCT)) u_dec (
    .valid_i (in_valid_i),
    .opcode_i(opcode_i),
    .funct_i (funct_i),
    .op_o    (op_d)
  );

  alt_alu_core #(.DATA_W(DATA_W), .FLOOR(FLOOR)) u_core (
    .op_i(op_d),
    .a_i (opa_i),
    .b_i (opb_i),
    .y_o (y_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      thr_hit_o   <= 1'b0;
      op_sel_o    <= 4'd0;
      result_o    <= '0;
    end else begin
      res_valid_o <= in_valid_i;
      thr_hit_o   <= (op_d == ALU_THR);
      op_sel_o    <= op_d;
      result_o    <= y_d;
    end
  end
endmodule

// File: rtl/alt_thresh_alu_chk.sv
module alt_thresh_alu_chk #(
  parameter int DATA_W    = 32,
  parameter int OPC_W     = 6,
  parameter int FN_W      = 6,
  parameter int FLOOR     = 1000,
  parameter int THR_FUNCT = 'h10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [FN_W-1:0]   funct_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              res_valid_o,
  input logic              thr_hit_o,
  input logic [3:0]        op_sel_o,
  input logic [DATA_W-1:0] result_o
);
  localparam logic signed [DATA_W-1:0] FL = DATA_W'(FLOOR);

  // R1
  thr_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && opcode_i == '0 && funct_i == FN_W'(THR_FUNCT))
      |=> (op_sel_o == 4'd9 && thr_hit_o));

  // R2
  thr_value_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && opcode_i == '0 && funct_i == FN_W'(THR_FUNCT))
      |=> (result_o[0] == ($signed($past(opa_i)) < FL && $signed($past(opb_i)) < FL)));

  // R3
  thr_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    thr_hit_o |-> (result_o[DATA_W-1:1] == '0));

  // R5
  foreign_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && opcode_i != '0) |=> (op_sel_o == 4'd0 && result_o == '0 && !thr_hit_o));

  // R6
  idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> (!res_valid_o && op_sel_o == 4'd0 && result_o == '0));

  // R6
  issue_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> res_valid_o);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid_o && !thr_hit_o && op_sel_o == 4'd0 && result_o == '0));
endmodule

bind alt_thresh_alu alt_thresh_alu_chk #(
  .DATA_W(DATA_W), .OPC_W(OPC_W), .FN_W(FN_W), .FLOOR(FLOOR), .THR_FUNCT(THR_FUNCT)
) u_chk (.*);

// File: tb/alt_thresh_alu_bench.sv
module alt_thresh_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [5:0]  funct_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        res_valid_o, thr_hit_o;
  logic [3:0]  op_sel_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alt_thresh_alu u_alt_thresh_alu (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic issue(input logic [5:0] opc, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid_i = 1'b1; opcode_i = opc; funct_i = fn; opa_i = a; opb_i = b;
  endtask

  task automatic expect_out(input string req, input logic [3:0] sel,
                            input logic [31:0] res, input logic hit);
    @(negedge clk);
    chk({req, " valid"}, {31'd0, res_valid_o}, 32'd1);
    chk({req, " sel"}, {28'd0, op_sel_o}, {28'd0, sel});
    chk({req, " result"}, result_o, res);
    chk({req, " hit"}, {31'd0, thr_hit_o}, {31'd0, hit});
    in_valid_i = 1'b0;
  endtask

  task automatic one_thr(input string req, input int a, input int b, input logic exp);
    issue(6'd0, 6'h10, a, b);
    expect_out(req, 4'd9, {31'd0, exp}, 1'b1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R7 valid", {31'd0, res_valid_o}, 32'd0);
    chk("R7 result", result_o, 32'd0);
    chk("R7 sel", {28'd0, op_sel_o}, 32'd0);
    chk("R7 hit", {31'd0, thr_hit_o}, 32'd0);
  endtask

  task automatic t_threshold;
    one_thr("R2 both low", 5, 5, 1'b1);
    one_thr("R2 b high", 5, 2000, 1'b0);
    one_thr("R2 a high", 2000, 5, 1'b0);
    one_thr("R2 both high", 2000, 2000, 1'b0);
    one_thr("R2 999/999", 999, 999, 1'b1);
    one_thr("R2 1000/999", 1000, 999, 1'b0);
    one_thr("R2 999/1000", 999, 1000, 1'b0);
    one_thr("R2 1001/0", 1001, 0, 1'b0);
    one_thr("R2 negatives", -5, -70000, 1'b1);
    one_thr("R2 most negative", 32'h8000_0000, 0, 1'b1);
    one_thr("R2 neg/1000", -1, 1000, 1'b0);
    one_thr("R3 R1 max pos", 32'h7FFF_FFFF, 3, 1'b0);
  endtask

  task automatic t_legacy;
    issue(6'd0, 6'h20, 3, 4);          expect_out("R4 add", 4'd1, 32'd7, 1'b0);
    issue(6'd0, 6'h21, 10, 32'hFFFFFFFF); expect_out("R4 addu", 4'd1, 32'd9, 1'b0);
    issue(6'd0, 6'h22, 10, 3);         expect_out("R4 sub", 4'd2, 32'd7, 1'b0);
    issue(6'd0, 6'h23, 3, 10);         expect_out("R4 subu", 4'd2, 32'hFFFF_FFF9, 1'b0);
    issue(6'd0, 6'h24, 32'hF0F0, 32'hFF00); expect_out("R4 and", 4'd3, 32'hF000, 1'b0);
    issue(6'd0, 6'h25, 32'hF0F0, 32'hFF00); expect_out("R4 or", 4'd4, 32'hFFF0, 1'b0);
    issue(6'd0, 6'h26, 32'hF0F0, 32'hFF00); expect_out("R4 xor", 4'd5, 32'h0FF0, 1'b0);
    issue(6'd0, 6'h27, 32'hF0F0, 32'hFF00); expect_out("R4 nor", 4'd6, 32'hFFFF_000F, 1'b0);
    issue(6'd0, 6'h2A, -1, 1);         expect_out("R4 slt", 4'd7, 32'd1, 1'b0);
    issue(6'd0, 6'h2A, 999, 1000);     expect_out("R4 slt edge", 4'd7, 32'd1, 1'b0);
    issue(6'd0, 6'h2B, -1, 1);         expect_out("R4 sltu", 4'd8, 32'd0, 1'b0);
  endtask

  task automatic t_foreign;
    issue(6'd1, 6'h10, 5, 5);   expect_out("R5 opcode1 fn10", 4'd0, 32'd0, 1'b0);
    issue(6'd0, 6'h3F, 5, 5);   expect_out("R5 unknown fn", 4'd0, 32'd0, 1'b0);
    issue(6'd8, 6'h20, 3, 4);   expect_out("R5 opcode8 add", 4'd0, 32'd0, 1'b0);
  endtask

  task automatic t_back_to_back;
    // R6: add then threshold with no gap, then reverse
    issue(6'd0, 6'h20, 1, 2);
    @(negedge clk);
    chk("R6 b2b add result", result_o, 32'd3);
    chk("R6 b2b add hit", {31'd0, thr_hit_o}, 32'd0);
    opcode_i = 6'd0; funct_i = 6'h10; opa_i = 1; opb_i = 2;
    @(negedge clk);
    chk("R6 b2b thr result", result_o, 32'd1);
    chk("R6 b2b thr hit", {31'd0, thr_hit_o}, 32'd1);
    funct_i = 6'h20; opa_i = 40; opb_i = 2;
    @(negedge clk);
    chk("R6 b2b add2 result", result_o, 32'd42);
    chk("R6 b2b add2 hit", {31'd0, thr_hit_o}, 32'd0);
    in_valid_i = 1'b0; funct_i = 6'h10; opa_i = 1; opb_i = 1;
    @(negedge clk);
    chk("R6 idle valid", {31'd0, res_valid_o}, 32'd0);
    chk("R6 idle result", result_o, 32'd0);
    chk("R6 idle sel", {28'd0, op_sel_o}, 32'd0);
  endtask

  task automatic t_reset_mid;
    issue(6'd0, 6'h10, 1, 1);
    rst = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    chk("R7 mid valid", {31'd0, res_valid_o}, 32'd0);
    chk("R7 mid hit", {31'd0, thr_hit_o}, 32'd0);
    chk("R7 mid result", result_o, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_threshold;
    t_legacy;
    t_foreign;
    t_back_to_back;
    t_reset_mid;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule